// File: doc/BRIEF.md
# Autoboot Timeout Supervisor

This block decides, after power-up, whether a system boots by itself from flash or hands control to an operator console. Out of reset it lights a status LED and counts pulses from an external prescaled timer. The LED blinks once per pulse while the count runs. If the count reaches its limit and no serial byte has arrived, the block issues a single flash-load request. It then waits for the loader to report the result. If the load succeeds, it issues a start pulse and the application runs from address zero.

A serial byte that arrives before the limit cancels the automatic boot for good, and the block becomes a command decoder. Each further byte is turned into a one-cycle pulse on a one-hot command vector. The block then refuses new bytes until the operation it started reports completion. The restart key puts everything back to the reset state, countdown included.

Any failure reported by the loader or by a console operation freezes the block. The LED is held on, the reported error code is kept, and all inputs are ignored until reset.

Top module: `autoboot_supervisor`

## Requirements
- R1: One clock after a synchronous reset, the LED output is 1, and the load request, start pulse, command vector and frozen flag are all 0.
- R2: During the countdown, every timer pulse inverts the LED output on the clock edge that samples it.
- R3: On the 16th timer pulse after reset or restart, with no byte received, the load request rises for exactly one clock.
- R4: A valid byte received before the 16th pulse, or in the same cycle as the 16th pulse, ends the countdown with no load request. The byte is not decoded as a command. Later timer pulses neither toggle the LED nor raise the load request.
- R5: While a flash load is pending, a done report without a failure produces a one-clock start pulse. After that, bytes and timer pulses have no effect on any output.
- R6: In console mode, a received byte produces a one-clock pulse on the command vector, and the pulse sets exactly one bit. The bit is chosen as follows: bit 0 for 'h' (0x68, help), bit 1 for 'u' (0x75, serial upload), bit 2 for 'p' (0x70, program flash), bit 3 for 'e' (0x65, execute), and bit 4 for any other value except 'r'.
- R7: After a command pulse, received bytes are ignored until a done report arrives. The next byte after that is decoded again.
- R8: A received 'r' (0x72) in console mode produces no command pulse. It sets the LED to 1 and restarts the countdown from zero, so the automatic boot follows after 16 more pulses.
- R9: A failure report while a load or a console operation is pending sets the frozen flag, holds the LED at 1, and captures the error code input.
- R10: Once frozen, the block ignores bytes, timer pulses, done and failure reports until reset. The LED stays 1, and the load request, start and command outputs stay 0.
- R11: While frozen, the error code output keeps the first captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse from the prescaled timer |
| rx_valid_i | input | 1 | Received serial byte is valid this cycle |
| rx_data_i | input | 8 | Received serial byte |
| done_i | input | 1 | Pending load or console operation finished |
| fail_i | input | 1 | Pending operation failed (valid with or without done_i) |
| err_code_i | input | ERR_W | Error code that goes with fail_i |
| led_o | output | 1 | Status LED, high is lit |
| load_req_o | output | 1 | One-cycle request to load the image from flash |
| start_o | output | 1 | One-cycle request to start the application at address 0 |
| cmd_o | output | 5 | One-hot command pulse: help, upload, program, execute, bad |
| frozen_o | output | 1 | Block is locked after an error |
| err_code_o | output | ERR_W | Captured error code |

## Verification
On every cycle, the embedded assertions check the following:
- the load request, start and command outputs are single-cycle pulses;
- the command vector is at most one-hot;
- the LED toggles on each counted pulse;
- a frozen block stays frozen, keeps its LED lit and keeps its error code.

Only the directed scenarios can show the following:
- the exact pulse count before the load request;
- the race between the last pulse and a key;
- which character maps to which command bit;
- that bytes are ignored while an operation is pending;
- that a restart brings back a full fresh countdown.

// File: rtl/abs_pkg.sv
package abs_pkg;
  typedef enum logic [2:0] {
    ST_COUNT,
    ST_LOAD,
    ST_RUN,
    ST_CONSOLE,
    ST_BUSY,
    ST_FROZEN
  } state_e;

  localparam int CMD_N    = 5;
  localparam int CMD_HELP = 0;
  localparam int CMD_UPLD = 1;
  localparam int CMD_PROG = 2;
  localparam int CMD_EXEC = 3;
  localparam int CMD_BAD  = 4;

  localparam logic [7:0] KEY_HELP    = 8'h68;
  localparam logic [7:0] KEY_UPLD    = 8'h75;
  localparam logic [7:0] KEY_PROG    = 8'h70;
  localparam logic [7:0] KEY_EXEC    = 8'h65;
  localparam logic [7:0] KEY_RESTART = 8'h72;
endpackage

// File: rtl/abs_countdown.sv
module abs_countdown #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic force_on_i,
  output logic led_o,
  output logic expire_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic          led_q;
  logic          step;

  assign step     = run_i && tick_i;
  assign expire_o = step && (cnt_q == LAST);
  assign led_o    = led_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (step && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i || force_on_i) begin
      led_q <= 1'b1;
    end else if (step) begin
      led_q <= ~led_q;
    end
  end

  // R2
  led_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clr_i && !force_on_i) |=> (led_q != $past(led_q)));
endmodule

// File: rtl/abs_decode.sv
module abs_decode
  import abs_pkg::*;
(
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic [CMD_N-1:0] cmd_o,
  output logic             restart_o
);
  always_comb begin
    cmd_o     = '0;
    restart_o = 1'b0;
    if (valid_i) begin
      unique case (data_i)
        KEY_HELP:    cmd_o[CMD_HELP] = 1'b1;
        KEY_UPLD:    cmd_o[CMD_UPLD] = 1'b1;
        KEY_PROG:    cmd_o[CMD_PROG] = 1'b1;
        KEY_EXEC:    cmd_o[CMD_EXEC] = 1'b1;
        KEY_RESTART: restart_o       = 1'b1;
        default:     cmd_o[CMD_BAD]  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/abs_errhold.sv
module abs_errhold #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [ERR_W-1:0] code_i,
  output logic             frozen_o,
  output logic [ERR_W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_o <= 1'b0;
      code_o   <= '0;
    end else if (capture_i && !frozen_o) begin
      frozen_o <= 1'b1;
      code_o   <= code_i;
    end
  end

  // R10
  frozen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frozen_o |=> frozen_o);

  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && $past(frozen_o)) |-> $stable(code_o));
endmodule

// File: rtl/autoboot_supervisor.sv
module autoboot_supervisor
  import abs_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int TIMEOUT_SEC   = 4,
  parameter int ERR_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             done_i,
  input  logic             fail_i,
  input  logic [ERR_W-1:0] err_code_i,
  output logic             led_o,
  output logic             load_req_o,
  output logic             start_o,
  output logic [4:0]       cmd_o,
  output logic             frozen_o,
  output logic [ERR_W-1:0] err_code_o
);
  localparam int TICKS = TICKS_PER_SEC * TIMEOUT_SEC;

  state_e           state_q, state_d;
  logic             run_cnt, expire, restart, to_frozen;
  logic [CMD_N-1:0] dec_cmd;
  logic             dec_restart;
  logic             load_req_q, start_q;
  logic [CMD_N-1:0] cmd_q;

  assign run_cnt = (state_q == ST_COUNT) && !rx_valid_i;

  abs_countdown #(.TICKS(TICKS)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (restart),
    .run_i      (run_cnt),
    .tick_i     (tick_i),
    .force_on_i (to_frozen),
    .led_o      (led_o),
    .expire_o   (expire)
  );

  abs_decode u_dec (
    .valid_i   (rx_valid_i),
    .data_i    (rx_data_i),
    .cmd_o     (dec_cmd),
    .restart_o (dec_restart)
  );

  abs_errhold #(.ERR_W(ERR_W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .capture_i (to_frozen),
    .code_i    (err_code_i),
    .frozen_o  (frozen_o),
    .code_o    (err_code_o)
  );

  always_comb begin
    state_d   = state_q;
    restart   = 1'b0;
    to_frozen = 1'b0;
    unique case (state_q)
      ST_COUNT: begin
        if (rx_valid_i)  state_d = ST_CONSOLE;
        else if (expire) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (fail_i) begin
          to_frozen = 1'b1;
          state_d   = ST_FROZEN;
        end else if (done_i) begin
          state_d = ST_RUN;
        end
      end
      ST_CONSOLE: begin
        if (rx_valid_i) begin
          if (dec_restart) begin
            restart = 1'b1;
            state_d = ST_COUNT;
          end else begin
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (fail_i) begin
          to_frozen = 1'b1;
          state_d   = ST_FROZEN;
        end else if (done_i) begin
          state_d = ST_CONSOLE;
        end
      end
      ST_RUN:    state_d = ST_RUN;
      ST_FROZEN: state_d = ST_FROZEN;
      default:   state_d = ST_FROZEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_COUNT;
      load_req_q <= 1'b0;
      start_q    <= 1'b0;
      cmd_q      <= '0;
    end else begin
      state_q    <= state_d;
      load_req_q <= expire;
      start_q    <= (state_q == ST_LOAD) && done_i && !fail_i;
      cmd_q      <= (state_q == ST_CONSOLE && !dec_restart) ? dec_cmd : '0;
    end
  end

  assign load_req_o = load_req_q;
  assign start_o    = start_q;
  assign cmd_o      = cmd_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (led_o && !load_req_o && !start_o && cmd_o == '0 && !frozen_o));

  // R3
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_req_o |=> !load_req_o);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R6
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_o));

  // R6
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != '0) |=> (cmd_o == '0));

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && !done_i) |=> (cmd_o == '0));

  // R9
  frozen_led_chk: assert property (@(posedge clk) disable iff (rst)
    frozen_o |-> led_o);

  // R10
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && $past(frozen_o)) |-> (!load_req_o && !start_o && cmd_o == '0));
endmodule

// File: tb/autoboot_supervisor_test.sv
module autoboot_supervisor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       done_i = 1'b0;
  logic       fail_i = 1'b0;
  logic [7:0] err_code_i = 8'h00;
  logic       led_o, load_req_o, start_o, frozen_o;
  logic [4:0] cmd_o;
  logic [7:0] err_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  autoboot_supervisor uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .done_i(done_i), .fail_i(fail_i),
    .err_code_i(err_code_i), .led_o(led_o), .load_req_o(load_req_o),
    .start_o(start_o), .cmd_o(cmd_o), .frozen_o(frozen_o),
    .err_code_o(err_code_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin rx_valid_i = 1'b1; rx_data_i = b; end
    @(negedge clk) rx_valid_i = 1'b0;
  endtask

  task automatic report(input logic f, input logic [7:0] code);
    @(negedge clk) begin done_i = 1'b1; fail_i = f; err_code_i = code; end
    @(negedge clk) begin done_i = 1'b0; fail_i = 1'b0; end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 led", led_o, 1);
    check("R1 load_req", load_req_o, 0);
    check("R1 start", start_o, 0);
    check("R1 cmd", cmd_o, 0);
    check("R1 frozen", frozen_o, 0);
  endtask

  task automatic t_autoboot();
    do_reset();
    for (int k = 1; k <= 15; k++) begin
      do_tick();
      check("R2 led toggle", led_o, (k % 2 == 0) ? 1 : 0);
      check("R3 no early load", load_req_o, 0);
    end
    do_tick();
    check("R3 load_req rises", load_req_o, 1);
    @(negedge clk);
    check("R3 load_req one cycle", load_req_o, 0);
    report(1'b0, 8'h00);
    check("R5 start pulse", start_o, 1);
    @(negedge clk);
    check("R5 start one cycle", start_o, 0);
    send_byte(8'h68);
    check("R5 byte ignored after start", cmd_o, 0);
    do_tick();
    check("R5 led frozen after start", led_o, 1);
    check("R5 no load after start", load_req_o, 0);
  endtask

  task automatic t_abort();
    do_reset();
    for (int k = 0; k < 5; k++) do_tick();
    send_byte(8'h68);
    check("R4 abort byte not decoded", cmd_o, 0);
    for (int k = 0; k < 20; k++) begin
      do_tick();
      check("R4 no load after abort", load_req_o, 0);
    end
    check("R4 led stops toggling", led_o, 0);
    // tie: key and the 16th pulse in the same cycle
    do_reset();
    for (int k = 0; k < 15; k++) do_tick();
    @(negedge clk) begin tick_i = 1'b1; rx_valid_i = 1'b1; rx_data_i = 8'h41; end
    @(negedge clk) begin tick_i = 1'b0; rx_valid_i = 1'b0; end
    check("R4 tie no load", load_req_o, 0);
    check("R4 tie no cmd", cmd_o, 0);
    send_byte(8'h70);
    check("R4 tie enters console", cmd_o, 5'b00100);
    report(1'b0, 8'h00);
  endtask

  task automatic t_cmds();
    do_reset();
    send_byte(8'h20);
    send_byte(8'h68); check("R6 help", cmd_o, 5'b00001);
    @(negedge clk);    check("R6 pulse one cycle", cmd_o, 0);
    report(1'b0, 8'h00);
    send_byte(8'h75); check("R6 upload", cmd_o, 5'b00010);
    report(1'b0, 8'h00);
    send_byte(8'h70); check("R6 program", cmd_o, 5'b00100);
    report(1'b0, 8'h00);
    send_byte(8'h65); check("R6 execute", cmd_o, 5'b01000);
    report(1'b0, 8'h00);
    send_byte(8'h7a); check("R6 bad", cmd_o, 5'b10000);
    report(1'b0, 8'h00);
  endtask

  task automatic t_busy();
    do_reset();
    send_byte(8'h00);
    send_byte(8'h75); check("R7 first cmd", cmd_o, 5'b00010);
    send_byte(8'h70); check("R7 ignored while busy", cmd_o, 0);
    send_byte(8'h72); check("R7 restart ignored while busy", led_o, 1);
    report(1'b0, 8'h00);
    send_byte(8'h70); check("R7 accepted after done", cmd_o, 5'b00100);
    report(1'b0, 8'h00);
  endtask

  task automatic t_restart();
    do_reset();
    do_tick();
    send_byte(8'h31);
    check("R8 led off before restart", led_o, 0);
    send_byte(8'h72);
    check("R8 no cmd on restart", cmd_o, 0);
    check("R8 led on after restart", led_o, 1);
    for (int k = 0; k < 15; k++) begin
      do_tick();
      check("R8 fresh countdown", load_req_o, 0);
    end
    do_tick();
    check("R8 autoboot after restart", load_req_o, 1);
    report(1'b0, 8'h00);
  endtask

  task automatic t_err_boot();
    do_reset();
    for (int k = 0; k < 16; k++) do_tick();
    report(1'b1, 8'h08);
    check("R9 frozen", frozen_o, 1);
    check("R9 led on", led_o, 1);
    check("R9 code", err_code_o, 8'h08);
    check("R9 no start", start_o, 0);
    do_tick();
    check("R10 led held", led_o, 1);
    send_byte(8'h68);
    check("R10 byte ignored", cmd_o, 0);
    send_byte(8'h72);
    check("R10 restart ignored", frozen_o, 1);
    report(1'b1, 8'h04);
    check("R11 code kept", err_code_o, 8'h08);
    report(1'b0, 8'h00);
    check("R10 no start", start_o, 0);
    check("R10 no load", load_req_o, 0);
  endtask

  task automatic t_err_console();
    do_reset();
    send_byte(8'h0d);
    send_byte(8'h75);
    report(1'b1, 8'h02);
    check("R9 console frozen", frozen_o, 1);
    check("R9 console code", err_code_o, 8'h02);
    check("R9 console led", led_o, 1);
    do_reset();
    check("R1 reset clears freeze", frozen_o, 0);
  endtask

  initial begin
    t_reset();
    t_autoboot();
    t_abort();
    t_cmds();
    t_busy();
    t_restart();
    t_err_boot();
    t_err_console();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule